// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block reads a passive row/column key matrix of between 3x3 and 8x8 keys. It pulls one row line low at a time and lets the line settle for a fixed number of cycles. It then samples the active-low column lines and builds a full snapshot of the matrix once per scan. Each key is debounced on its own. A key changes state only after a programmable number of consecutive full scans disagree with its current state. Accepted changes set bits in separate press and release bitmaps, which software clears by writing ones. An interrupt line stays high while any bit in either bitmap is set.

A low-power wake mode stops the scan and drives all in-size row lines low together. Any pressed key in the configured area then raises a wake output without walking the rows. A key-combination detector compares three programmable key numbers against the debounced key map. It requests a reset while all three keys are held.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, `scan_out_n` is 8'hFE (row 0 low). `key_map`, `press_stat`, `release_stat`, `irq`, `wake` and `reset_req` are all zero.
- R2: When not in wake mode, exactly one row line is low. The low line steps through rows 0 up to the last configured row and then wraps to row 0. Each row is held for SETTLE+1 cycles, and the column lines are sampled in the last of those cycles. A key at row r, column c is bit r*8+c of every 64-bit map.
- R3: A size value below 3 is treated as 3, and a value above 8 is treated as 8. Keys in rows or columns outside the effective size never appear in `key_map` and never raise `wake`.
- R4: A key changes state in `key_map` only after `cfg_debounce` consecutive full scans have seen the opposite level (a setting of 0 acts as 1). A press held for fewer scans than that is never accepted.
- R5: A key accepted as pressed sets its bit in `press_stat`.
- R6: A key accepted as released sets its bit in `release_stat`.
- R7: Writing 1 to a bit of `clr_press` or `clr_release` clears that status bit, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear. `irq` is high exactly while any status bit is set.
- R8: While `wake_mode` is high, every in-size row line is driven low and rows beyond the size stay high. `wake` goes high one cycle after any in-size column line reads low, and is low whenever `wake_mode` was low. `key_map` does not change while scanning is parked.
- R9: `reset_req` is high one cycle after `combo_en` is high and the three keys numbered `combo_a`, `combo_b` and `combo_c` are all pressed in `key_map`. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rows | input | 4 | Number of rows scanned (clamped to 3..8) |
| cfg_cols | input | 4 | Number of columns read (clamped to 3..8) |
| cfg_debounce | input | 4 | Full scans a change must persist before it is accepted |
| wake_mode | input | 1 | Park the scan and watch for any key |
| combo_en | input | 1 | Enable the three-key reset detector |
| combo_a | input | 6 | First key number of the reset combination |
| combo_b | input | 6 | Second key number of the reset combination |
| combo_c | input | 6 | Third key number of the reset combination |
| scan_in_n | input | 8 | Column sense lines, low when a key on the driven row is closed |
| clr_press | input | 64 | Write-1-to-clear mask for press status |
| clr_release | input | 64 | Write-1-to-clear mask for release status |
| scan_out_n | output | 8 | Row drive lines, active low |
| key_map | output | 64 | Debounced key state, bit r*8+c |
| press_stat | output | 64 | Sticky press events |
| release_stat | output | 64 | Sticky release events |
| irq | output | 1 | High while any status bit is set |
| wake | output | 1 | Any-key indication in wake mode |
| reset_req | output | 1 | Three-key reset request |

## Verification
The assertions assume the column lines come from a passive matrix. Each column is the AND of the closed keys on whichever rows are driven low, so a key can only pull a column low through a driven row. They also assume that `wake_mode` and the configuration change only between clock edges. The bench keeps to this with a matrix model that drives `scan_in_n` directly from `scan_out_n` and a held-key vector. It changes the configuration and `wake_mode` only at falling edges. It presses only key sets with no two keys sharing a row or column, so no phantom keys appear.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int MIN_DIM = 3;

    function automatic int clamp_dim(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction
endpackage

// File: rtl/kp_scan_seq.sv
module kp_scan_seq #(
    parameter  int MAX_DIM = 8,
    parameter  int SETTLE  = 2,
    localparam int DIM_W   = $clog2(MAX_DIM + 1),
    localparam int KEYS    = MAX_DIM * MAX_DIM
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               park,
    input  logic [DIM_W-1:0]   rows_eff,
    input  logic [DIM_W-1:0]   cols_eff,
    input  logic [MAX_DIM-1:0] scan_in_n,
    output logic [MAX_DIM-1:0] scan_out_n,
    output logic [KEYS-1:0]    frame,
    output logic               frame_done
);
    localparam int ROW_W = $clog2(MAX_DIM);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] cnt;
        logic [KEYS-1:0]  acc;
        logic             done;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        logic [KEYS-1:0] nxt_acc;
        s_d      = s_q;
        s_d.done = 1'b0;
        nxt_acc  = s_q.acc;
        if (park) begin
            s_d.row = '0;
            s_d.cnt = '0;
        end else if (s_q.cnt == CNT_W'(SETTLE)) begin
            if (s_q.row == '0) nxt_acc = '0;
            for (int c = 0; c < MAX_DIM; c++) begin
                nxt_acc[int'(s_q.row) * MAX_DIM + c] = (c < int'(cols_eff)) && !scan_in_n[c];
            end
            s_d.acc = nxt_acc;
            s_d.cnt = '0;
            if (int'(s_q.row) + 1 >= int'(rows_eff)) begin
                s_d.row  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.row = s_q.row + 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int r = 0; r < MAX_DIM; r++) begin
            if (park) scan_out_n[r] = !(r < int'(rows_eff));
            else      scan_out_n[r] = (r != int'(s_q.row));
        end
    end

    assign frame      = s_q.acc;
    assign frame_done = s_q.done;
endmodule

// File: rtl/kp_debounce.sv
module kp_debounce #(
    parameter int KEYS = 64,
    parameter int DB_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_done,
    input  logic [KEYS-1:0] frame,
    input  logic [DB_W-1:0] db_len,
    output logic [KEYS-1:0] key_map,
    output logic [KEYS-1:0] press_ev,
    output logic [KEYS-1:0] rel_ev
);
    typedef struct packed {
        logic [DB_W-1:0] cnt;
        logic            state;
        logic            up;
        logic            dn;
    } cell_t;

    logic [DB_W-1:0] lim;
    assign lim = (db_len == '0) ? '0 : db_len - 1'b1;

    for (genvar k = 0; k < KEYS; k++) begin : g_cell
        cell_t c_q, c_d;

        always_comb begin
            c_d    = c_q;
            c_d.up = 1'b0;
            c_d.dn = 1'b0;
            if (frame_done) begin
                if (frame[k] != c_q.state) begin
                    if (c_q.cnt >= lim) begin
                        c_d.state = frame[k];
                        c_d.cnt   = '0;
                        c_d.up    = frame[k];
                        c_d.dn    = !frame[k];
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end else begin
                    c_d.cnt = '0;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign key_map[k]  = c_q.state;
        assign press_ev[k] = c_q.up;
        assign rel_ev[k]   = c_q.dn;
    end
endmodule

// File: rtl/kp_status.sv
module kp_status #(
    parameter int KEYS = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [KEYS-1:0] press_ev,
    input  logic [KEYS-1:0] rel_ev,
    input  logic [KEYS-1:0] clr_press,
    input  logic [KEYS-1:0] clr_rel,
    output logic [KEYS-1:0] press_stat,
    output logic [KEYS-1:0] rel_stat,
    output logic            irq
);
    typedef struct packed {
        logic [KEYS-1:0] prs;
        logic [KEYS-1:0] rel;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d.prs = (st_q.prs & ~clr_press) | press_ev;
        st_d.rel = (st_q.rel & ~clr_rel)   | rel_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign press_stat = st_q.prs;
    assign rel_stat   = st_q.rel;
    assign irq        = (|st_q.prs) | (|st_q.rel);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter  int MAX_DIM = 8,
    parameter  int SETTLE  = 2,
    parameter  int DB_W    = 4,
    localparam int DIM_W   = $clog2(MAX_DIM + 1),
    localparam int KEYS    = MAX_DIM * MAX_DIM,
    localparam int IDX_W   = $clog2(KEYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIM_W-1:0]   cfg_rows,
    input  logic [DIM_W-1:0]   cfg_cols,
    input  logic [DB_W-1:0]    cfg_debounce,
    input  logic               wake_mode,
    input  logic               combo_en,
    input  logic [IDX_W-1:0]   combo_a,
    input  logic [IDX_W-1:0]   combo_b,
    input  logic [IDX_W-1:0]   combo_c,
    input  logic [MAX_DIM-1:0] scan_in_n,
    input  logic [KEYS-1:0]    clr_press,
    input  logic [KEYS-1:0]    clr_release,
    output logic [MAX_DIM-1:0] scan_out_n,
    output logic [KEYS-1:0]    key_map,
    output logic [KEYS-1:0]    press_stat,
    output logic [KEYS-1:0]    release_stat,
    output logic               irq,
    output logic               wake,
    output logic               reset_req
);
    logic [DIM_W-1:0] rows_eff, cols_eff;
    logic [KEYS-1:0]  frame, press_ev, rel_ev;
    logic             frame_done;

    assign rows_eff = DIM_W'(kp_pkg::clamp_dim(int'(cfg_rows), kp_pkg::MIN_DIM, MAX_DIM));
    assign cols_eff = DIM_W'(kp_pkg::clamp_dim(int'(cfg_cols), kp_pkg::MIN_DIM, MAX_DIM));

    kp_scan_seq #(.MAX_DIM(MAX_DIM), .SETTLE(SETTLE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .park       (wake_mode),
        .rows_eff   (rows_eff),
        .cols_eff   (cols_eff),
        .scan_in_n  (scan_in_n),
        .scan_out_n (scan_out_n),
        .frame      (frame),
        .frame_done (frame_done)
    );

    kp_debounce #(.KEYS(KEYS), .DB_W(DB_W)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame      (frame),
        .db_len     (cfg_debounce),
        .key_map    (key_map),
        .press_ev   (press_ev),
        .rel_ev     (rel_ev)
    );

    kp_status #(.KEYS(KEYS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .press_ev   (press_ev),
        .rel_ev     (rel_ev),
        .clr_press  (clr_press),
        .clr_rel    (clr_release),
        .press_stat (press_stat),
        .rel_stat   (release_stat),
        .irq        (irq)
    );

    typedef struct packed {
        logic wake;
        logic rreq;
    } top_t;

    top_t t_q, t_d;

    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int c = 0; c < MAX_DIM; c++) begin
            hit = hit | ((c < int'(cols_eff)) && !scan_in_n[c]);
        end
        t_d.wake = wake_mode && hit;
        t_d.rreq = combo_en && key_map[combo_a] && key_map[combo_b] && key_map[combo_c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign wake      = t_q.wake;
    assign reset_req = t_q.rreq;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
    parameter int MAX_DIM = 8,
    parameter int KEYS    = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wake_mode,
    input logic               combo_en,
    input logic [MAX_DIM-1:0] scan_out_n,
    input logic [KEYS-1:0]    key_map,
    input logic [KEYS-1:0]    press_stat,
    input logic [KEYS-1:0]    release_stat,
    input logic               wake,
    input logic               reset_req
);
    logic [KEYS-1:0] prev_q;
    logic [KEYS-1:0] rose, fell;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= key_map;
    end

    assign rose = key_map & ~prev_q;
    assign fell = prev_q & ~key_map;

    a_r2_single_row_low: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_mode |-> $countones(~scan_out_n) == 1);

    a_r5_press_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (rose != '0) |=> ((press_stat & $past(rose)) == $past(rose)));

    a_r6_release_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (fell != '0) |=> ((release_stat & $past(fell)) == $past(fell)));

    a_r8_park_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        wake_mode |-> (scan_out_n[2:0] == 3'b000));

    a_r8_wake_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(wake_mode));

    a_r8_map_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_mode && $past(wake_mode) && $past(wake_mode, 2)) |-> $stable(key_map));

    a_r9_combo_gated: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(combo_en));
endmodule

bind keypad_scanner kp_checker #(.MAX_DIM(MAX_DIM), .KEYS(KEYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wake_mode    (wake_mode),
    .combo_en     (combo_en),
    .scan_out_n   (scan_out_n),
    .key_map      (key_map),
    .press_stat   (press_stat),
    .release_stat (release_stat),
    .wake         (wake),
    .reset_req    (reset_req)
);

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 2;
    localparam int T_MAX      = 8 * (SETTLE + 1);
    localparam int W          = 4 * T_MAX + 10;

    typedef struct packed {
        logic [3:0] rows;
        logic [3:0] cols;
        logic [5:0] idx;
        logic       seen;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd8,  4'd8,  6'd0,  1'b1},
        '{4'd8,  4'd8,  6'd63, 1'b1},
        '{4'd8,  4'd8,  6'd9,  1'b1},
        '{4'd4,  4'd4,  6'd27, 1'b1},
        '{4'd4,  4'd4,  6'd28, 1'b0},
        '{4'd4,  4'd4,  6'd35, 1'b0},
        '{4'd3,  4'd3,  6'd18, 1'b1},
        '{4'd3,  4'd3,  6'd19, 1'b0},
        '{4'd2,  4'd2,  6'd18, 1'b1},
        '{4'd5,  4'd7,  6'd38, 1'b1},
        '{4'd5,  4'd7,  6'd39, 1'b0},
        '{4'd12, 4'd12, 6'd63, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rows = 4'd4, cfg_cols = 4'd8, cfg_debounce = 4'd2;
    logic        wake_mode = 1'b0, combo_en = 1'b0;
    logic [5:0]  combo_a = '0, combo_b = '0, combo_c = '0;
    logic [7:0]  scan_in_n;
    logic [63:0] clr_press = '0, clr_release = '0;
    logic [7:0]  scan_out_n;
    logic [63:0] key_map, press_stat, release_stat;
    logic        irq, wake, reset_req;
    logic [63:0] pressed = '0;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < 8; c++) begin
            scan_in_n[c] = 1'b1;
            for (int r = 0; r < 8; r++) begin
                if (!scan_out_n[r] && pressed[r * 8 + c]) scan_in_n[c] = 1'b0;
            end
        end
    end

    keypad_scanner #(.MAX_DIM(8), .SETTLE(SETTLE), .DB_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_debounce(cfg_debounce), .wake_mode(wake_mode), .combo_en(combo_en),
        .combo_a(combo_a), .combo_b(combo_b), .combo_c(combo_c),
        .scan_in_n(scan_in_n), .clr_press(clr_press), .clr_release(clr_release),
        .scan_out_n(scan_out_n), .key_map(key_map), .press_stat(press_stat),
        .release_stat(release_stat), .irq(irq), .wake(wake), .reset_req(reset_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic clear_all();
        clr_press   = '1;
        clr_release = '1;
        tick(1);
        clr_press   = '0;
        clr_release = '0;
    endtask

    task automatic sweep(input string req, input int rows_exp, input int n);
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            if (scan_out_n !== ~(8'd1 << ((i / (SETTLE + 1)) % rows_exp))) errs++;
            tick(1);
        end
        chk(req, 64'(errs), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=expired exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(1);
        do_reset();
        // R1 reset state
        chk("R1 scan_out", 64'(scan_out_n), 64'hFE);
        chk("R1 key_map", key_map, 64'd0);
        chk("R1 stats", press_stat | release_stat, 64'd0);
        chk("R1 flags", {61'd0, irq, wake, reset_req}, 64'd0);

        // R2 row walk with 4 rows
        sweep("R2 walk 4 rows", 4, 36);
        // R3 clamp low and high
        cfg_rows = 4'd1;
        do_reset();
        sweep("R3 rows clamp to 3", 3, 27);
        cfg_rows = 4'd12;
        do_reset();
        sweep("R3 rows clamp to 8", 8, 60);

        // vector table walk: R2 R3 R4 R5 R6 R7
        cfg_debounce = 4'd2;
        for (int v = 0; v < NV; v++) begin
            logic [63:0] e;
            cfg_rows = VEC[v].rows;
            cfg_cols = VEC[v].cols;
            e = VEC[v].seen ? (64'd1 << VEC[v].idx) : 64'd0;
            tick(1);
            pressed = 64'd1 << VEC[v].idx;
            tick(W);
            chk($sformatf("R3 key_map vec%0d", v), key_map, e);
            chk($sformatf("R5 press_stat vec%0d", v), press_stat, e);
            chk($sformatf("R7 irq vec%0d", v), 64'(irq), 64'(VEC[v].seen));
            pressed = '0;
            tick(W);
            chk($sformatf("R4 released vec%0d", v), key_map, 64'd0);
            chk($sformatf("R6 release_stat vec%0d", v), release_stat, e);
            clear_all();
            chk($sformatf("R7 cleared vec%0d", v), {press_stat | release_stat}, 64'd0);
        end

        // R4 debounce timing, 4 scans
        cfg_rows = 4'd8;
        cfg_cols = 4'd8;
        cfg_debounce = 4'd4;
        tick(1);
        pressed = 64'd1 << 20;
        tick(70);
        chk("R4 not yet accepted", key_map, 64'd0);
        tick(60);
        chk("R4 accepted", key_map, 64'd1 << 20);
        pressed = '0;
        tick(130);
        clear_all();
        // R4 short press rejected
        pressed = 64'd1 << 44;
        tick(30);
        pressed = '0;
        tick(150);
        chk("R4 short press map", key_map, 64'd0);
        chk("R4 short press stat", press_stat, 64'd0);
        // R4 setting 0 acts as 1
        cfg_debounce = 4'd0;
        pressed = 64'd1 << 12;
        tick(55);
        chk("R4 zero debounce press", key_map, 64'd1 << 12);
        pressed = '0;
        tick(55);
        chk("R4 zero debounce release", key_map, 64'd0);
        clear_all();

        // R7 write-1-to-clear
        cfg_debounce = 4'd2;
        pressed = 64'd1 << 5;
        tick(W);
        chk("R5 press bit5", press_stat, 64'd1 << 5);
        clr_press = 64'd1 << 6;
        tick(1);
        clr_press = '0;
        chk("R7 other bit keeps", press_stat, 64'd1 << 5);
        chk("R7 irq held", 64'(irq), 64'd1);
        clr_press = 64'd1 << 5;
        tick(1);
        clr_press = '0;
        chk("R7 bit cleared", press_stat, 64'd0);
        chk("R7 irq dropped", 64'(irq), 64'd0);
        pressed = '0;
        tick(W);
        chk("R6 release bit5", release_stat, 64'd1 << 5);
        chk("R7 irq on release", 64'(irq), 64'd1);
        clear_all();

        // R8 wake mode
        wake_mode = 1'b1;
        tick(1);
        chk("R8 all rows low", 64'(scan_out_n), 64'h00);
        chk("R8 no wake idle", 64'(wake), 64'd0);
        pressed = 64'd1 << 27;
        tick(1);
        chk("R8 wake raised", 64'(wake), 64'd1);
        tick(100);
        chk("R8 map frozen", key_map, 64'd0);
        pressed = '0;
        tick(1);
        chk("R8 wake cleared", 64'(wake), 64'd0);
        cfg_rows = 4'd4;
        cfg_cols = 4'd4;
        tick(1);
        chk("R8 in-size rows only", 64'(scan_out_n), 64'hF0);
        pressed = 64'd1 << 6;
        tick(2);
        chk("R3 wake ignores outside column", 64'(wake), 64'd0);
        pressed = '0;
        cfg_rows = 4'd8;
        cfg_cols = 4'd8;
        wake_mode = 1'b0;
        tick(W);

        // R9 three-key reset
        combo_a = 6'd0;
        combo_b = 6'd9;
        combo_c = 6'd18;
        combo_en = 1'b1;
        pressed = (64'd1 << 0) | (64'd1 << 9);
        tick(W);
        chk("R9 two keys no reset", 64'(reset_req), 64'd0);
        pressed = pressed | (64'd1 << 18);
        tick(W);
        chk("R9 three keys reset", 64'(reset_req), 64'd1);
        combo_en = 1'b0;
        tick(2);
        chk("R9 disabled", 64'(reset_req), 64'd0);
        combo_en = 1'b1;
        pressed = pressed & ~(64'd1 << 9);
        tick(W);
        chk("R9 one released", 64'(reset_req), 64'd0);
        pressed = '0;
        combo_en = 1'b0;
        tick(W);
        clear_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule